// File: doc/BRIEF.md
# Two-Level Interrupt Gate for a Small Processor Core

This block collects interrupt events for a small processor core and decides when the core must leave its program to service them. It has three core sources: an external pin with a selectable edge, a port-change event and a timer overflow. It also takes a parameterised group of peripheral event lines.

Every event sets a sticky flag. That flag stays set until software writes it to zero, and setting it does not depend on whether its enable is on. A request reaches the core only through three gates in series:

- the source's own enable,
- a shared group enable, which applies to peripheral sources only,
- a global enable.

When a request passes all three gates, the block raises a one-cycle take pulse and presents the fixed vector address. The core then pushes its return address and jumps to that vector. At the same moment the block drops the global enable, so the service routine cannot be re-entered. A return-from-interrupt event from the core sets the global enable again. A flag that software has not cleared by then takes the core straight back to the vector.

Software reaches the state through three byte-wide registers: a control register, a peripheral flag register and a peripheral enable register. The control register holds:

- the global enable in bit 7,
- the peripheral-group enable in bit 6,
- the core-source enables in bits 5..3,
- the core-source flags in bits 2..0.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset all flags, all enables and the global enable read 0, and `irq_take` is low.
- R2: With `pin_rise_sel`=1 a low-to-high change of `pin_async` sets control bit 2 (pin flag). With `pin_rise_sel`=0 a high-to-low change sets it. A change in the other direction leaves the flag at 0.
- R3: When the pin enable (control bit 5) and the global enable are 1, `irq_take` is high after the third rising clock edge that follows a qualifying pin change, and low after the first two.
- R4: A port-change event sets control bit 1, and a timer overflow event sets control bit 0. Each peripheral event line sets its bit of the peripheral flag register. All of these flags are set whatever the state of their enables, and a masked flag leaves `irq_take` low.
- R5: When hardware sets a flag in the same cycle that software writes that flag to 0, the flag reads 1 afterwards.
- R6: Flags are never cleared by hardware. They change from 1 to 0 only through a software write of 0.
- R7: For core sources, `irq_take` = global enable AND (any control flag in bits 2..0 whose enable, 3 bit positions higher, is 1).
- R8: A peripheral flag requests only when its bit in the peripheral enable register, the group enable (control bit 6) and the global enable are all 1.
- R9: `irq_take` lasts one cycle, the global enable reads 0 after the edge at which `irq_take` was high, and `irq_vector` equals the vector address parameter (0x0004 by default).
- R10: A `ret_evt` pulse sets the global enable. If an enabled flag is still set, `irq_take` is high again at once.
- R11: Software writes and reads the global enable through control bit 7. When both happen in the same cycle, a take clears the enable and overrides both the write and `ret_evt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | External interrupt pin, asynchronous |
| pin_rise_sel | input | 1 | 1 = rising edge, 0 = falling edge |
| port_chg_evt | input | 1 | Port-change event pulse |
| tmr_ovf_evt | input | 1 | Timer overflow event pulse |
| periph_evt | input | NUM_PERIPH | Peripheral event pulses |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents |
| pflag_wr | input | 1 | Peripheral flag register write strobe |
| pflag_wdata | input | NUM_PERIPH | Peripheral flag write data |
| pflag_rdata | output | NUM_PERIPH | Peripheral flags |
| pen_wr | input | 1 | Peripheral enable register write strobe |
| pen_wdata | input | NUM_PERIPH | Peripheral enable write data |
| pen_rdata | output | NUM_PERIPH | Peripheral enables |
| ret_evt | input | 1 | Return-from-interrupt executed by the core |
| irq_take | output | 1 | Vector now: push return address and jump |
| irq_vector | output | ADDR_W | Fixed vector address |

## Verification
The bench builds the block with five peripheral lines. This odd width checks that the flag and enable banks and the group gate work for a width that is not a power of two. The default two-stage synchronizer is kept, which fixes the pin latency at exactly three edges, so R3 can be checked against exact cycle counts. Directed sequences cover both edge polarities, masked sources, set-versus-clear collisions and re-entry on return. A long random phase then mixes register writes, return events and event pulses against a bench model of the flags and the gates.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   localparam int CTL_W      = 8;
   localparam int NUM_CORE   = 3;
   localparam int FLAG_LSB   = 0;
   localparam int EN_LSB     = 3;
   localparam int PGATE_BIT  = 6;
   localparam int GLOBAL_BIT = 7;

   typedef enum logic [1:0] {
      SRC_TIMER = 2'd0,
      SRC_CHG   = 2'd1,
      SRC_PIN   = 2'd2
   } core_src_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   input  logic rise_sel,
   output logic edge_hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;
   logic              synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   assign synced = chain[STAGES-1];

   always_comb begin
      if (rise_sel) edge_hit = synced & ~prev;
      else          edge_hit = ~synced & prev;
   end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("irq_flag_bank: W must be at least 1");
   end

   logic [W-1:0] base;

   assign base = wr_en ? wdata : q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= base | hw_set;
   end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter int NUM_PERIPH  = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 13,
   parameter int VEC_ADDR    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pin_async,
   input  logic                  pin_rise_sel,
   input  logic                  port_chg_evt,
   input  logic                  tmr_ovf_evt,
   input  logic [NUM_PERIPH-1:0] periph_evt,
   input  logic                  ctl_wr,
   input  logic [CTL_W-1:0]      ctl_wdata,
   output logic [CTL_W-1:0]      ctl_rdata,
   input  logic                  pflag_wr,
   input  logic [NUM_PERIPH-1:0] pflag_wdata,
   output logic [NUM_PERIPH-1:0] pflag_rdata,
   input  logic                  pen_wr,
   input  logic [NUM_PERIPH-1:0] pen_wdata,
   output logic [NUM_PERIPH-1:0] pen_rdata,
   input  logic                  ret_evt,
   output logic                  irq_take,
   output logic [ADDR_W-1:0]     irq_vector
);
   localparam int VEC_LIMIT = 1 << ADDR_W;

   if (NUM_PERIPH < 1 || NUM_PERIPH > 8) begin : g_bad_np
      $error("irq_gate_ctrl: NUM_PERIPH must be 1..8");
   end
   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_aw
      $error("irq_gate_ctrl: ADDR_W must be 4..24");
   end
   if (VEC_ADDR < 0 || VEC_ADDR >= VEC_LIMIT) begin : g_bad_vec
      $error("irq_gate_ctrl: VEC_ADDR does not fit ADDR_W");
   end

   logic                  pin_hit;
   logic [NUM_CORE-1:0]   core_set;
   logic [NUM_CORE-1:0]   core_flag;
   logic [NUM_CORE-1:0]   core_en;
   logic                  pgate;
   logic                  gie;
   logic [NUM_PERIPH-1:0] per_flag;
   logic [NUM_PERIPH-1:0] per_en;
   logic                  core_pend;
   logic                  per_pend;

   irq_edge_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pin_async),
      .rise_sel (pin_rise_sel),
      .edge_hit (pin_hit)
   );

   always_comb begin
      core_set            = '0;
      core_set[SRC_TIMER] = tmr_ovf_evt;
      core_set[SRC_CHG]   = port_chg_evt;
      core_set[SRC_PIN]   = pin_hit;
   end

   irq_flag_bank #(.W(NUM_CORE)) u_core_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ctl_wr),
      .wdata  (ctl_wdata[FLAG_LSB +: NUM_CORE]),
      .hw_set (core_set),
      .q      (core_flag)
   );

   irq_flag_bank #(.W(NUM_PERIPH)) u_per_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pflag_wr),
      .wdata  (pflag_wdata),
      .hw_set (periph_evt),
      .q      (per_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         core_en <= '0;
         pgate   <= 1'b0;
         per_en  <= '0;
      end else begin
         if (ctl_wr) begin
            core_en <= ctl_wdata[EN_LSB +: NUM_CORE];
            pgate   <= ctl_wdata[PGATE_BIT];
         end
         if (pen_wr) per_en <= pen_wdata;
      end
   end

   // Priority for the global enable: vectoring, then return, then software.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gie <= 1'b0;
      else if (irq_take) gie <= 1'b0;
      else if (ret_evt)  gie <= 1'b1;
      else if (ctl_wr)   gie <= ctl_wdata[GLOBAL_BIT];
   end

   assign core_pend = |(core_flag & core_en);
   assign per_pend  = |(per_flag & per_en);
   assign irq_take  = gie & (core_pend | (pgate & per_pend));

   assign irq_vector  = ADDR_W'(VEC_ADDR);
   assign ctl_rdata   = {gie, pgate, core_en, core_flag};
   assign pflag_rdata = per_flag;
   assign pen_rdata   = per_en;
endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
   parameter int NUM_PERIPH = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  irq_take,
   input logic                  ret_evt,
   input logic [7:0]            ctl_rdata,
   input logic                  pflag_wr,
   input logic [NUM_PERIPH-1:0] pflag_rdata,
   input logic [NUM_PERIPH-1:0] periph_evt,
   input logic                  port_chg_evt,
   input logic                  tmr_ovf_evt
);
   assert_take_drops_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !ctl_rdata[7]);

   assert_ret_raises_gie_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_evt && !irq_take) |=> ctl_rdata[7]);

   assert_take_needs_gie_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> ctl_rdata[7]);

   assert_pflag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pflag_wr |=> ((pflag_rdata & $past(pflag_rdata)) == $past(pflag_rdata)));

   assert_set_beats_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|periph_evt) |=> ((pflag_rdata & $past(periph_evt)) == $past(periph_evt)));

   assert_core_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (port_chg_evt || tmr_ovf_evt) |=>
         ((ctl_rdata[1:0] & $past({port_chg_evt, tmr_ovf_evt})) == $past({port_chg_evt, tmr_ovf_evt})));

   assert_periph_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && ((ctl_rdata[2:0] & ctl_rdata[5:3]) == 3'b000)) |-> ctl_rdata[6]);
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.NUM_PERIPH(NUM_PERIPH)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_take     (irq_take),
   .ret_evt      (ret_evt),
   .ctl_rdata    (ctl_rdata),
   .pflag_wr     (pflag_wr),
   .pflag_rdata  (pflag_rdata),
   .periph_evt   (periph_evt),
   .port_chg_evt (port_chg_evt),
   .tmr_ovf_evt  (tmr_ovf_evt)
);

// File: tb/irq_gate_ctrl_bench.sv
`timescale 1ns/1ps
module irq_gate_ctrl_bench;
   localparam int NP = 5;
   localparam int AW = 13;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pin_async, pin_rise_sel, port_chg_evt, tmr_ovf_evt;
   logic [NP-1:0] periph_evt;
   logic          ctl_wr;
   logic [7:0]    ctl_wdata, ctl_rdata;
   logic          pflag_wr, pen_wr, ret_evt, irq_take;
   logic [NP-1:0] pflag_wdata, pflag_rdata, pen_wdata, pen_rdata;
   logic [AW-1:0] irq_vector;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   always #2 clk = ~clk;

   irq_gate_ctrl #(.NUM_PERIPH(NP), .SYNC_STAGES(2), .ADDR_W(AW), .VEC_ADDR(4)) u_irq_gate_ctrl (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async), .pin_rise_sel(pin_rise_sel),
      .port_chg_evt(port_chg_evt), .tmr_ovf_evt(tmr_ovf_evt), .periph_evt(periph_evt),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .pflag_wr(pflag_wr), .pflag_wdata(pflag_wdata), .pflag_rdata(pflag_rdata),
      .pen_wr(pen_wr), .pen_wdata(pen_wdata), .pen_rdata(pen_rdata),
      .ret_evt(ret_evt), .irq_take(irq_take), .irq_vector(irq_vector)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic write_ctl(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      tick();
      ctl_wr = 1'b0;
   endtask

   function automatic logic take_model(input logic [7:0] c, input logic [NP-1:0] pf,
                                       input logic [NP-1:0] pe);
      return c[7] & ((|(c[2:0] & c[5:3])) | (c[6] & (|(pf & pe))));
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0]    m_ctl;
      logic [NP-1:0] m_pf, m_pe;
      logic          m_take;
      void'($urandom(32'd2718));
      rst_n = 1'b0; pin_async = 1'b0; pin_rise_sel = 1'b1; port_chg_evt = 1'b0;
      tmr_ovf_evt = 1'b0; periph_evt = '0; ctl_wr = 1'b0; ctl_wdata = '0;
      pflag_wr = 1'b0; pflag_wdata = '0; pen_wr = 1'b0; pen_wdata = '0; ret_evt = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
      chk(pflag_rdata == '0, "R1 pflag", pflag_rdata, 0);
      chk(pen_rdata == '0, "R1 pen", pen_rdata, 0);
      chk(irq_take == 1'b0, "R1 take", irq_take, 0);

      // R2/R3 rising pin edge, latency of three edges
      write_ctl(8'hA0);
      pin_async = 1'b1;
      tick(); tick();
      chk(irq_take == 1'b0, "R3 early take", irq_take, 0);
      tick();
      chk(irq_take == 1'b1, "R3 take at third edge", irq_take, 1);
      chk(ctl_rdata[2] == 1'b1, "R2 rising flag", ctl_rdata[2], 1);
      chk(irq_vector == 13'h0004, "R9 vector", irq_vector, 4);
      tick();
      chk(ctl_rdata[7] == 1'b0, "R9 gie cleared", ctl_rdata[7], 0);
      chk(irq_take == 1'b0, "R9 single pulse", irq_take, 0);
      repeat (4) tick();
      chk(ctl_rdata[2] == 1'b1, "R6 flag persists", ctl_rdata[2], 1);

      // R10 return with flag still set re-enters
      ret_evt = 1'b1; tick(); ret_evt = 1'b0;
      chk(ctl_rdata[7] == 1'b1, "R10 gie set", ctl_rdata[7], 1);
      chk(irq_take == 1'b1, "R10 re-entry", irq_take, 1);
      tick();
      write_ctl(8'h20);
      chk(ctl_rdata == 8'h20, "R6 software clear", ctl_rdata, 8'h20);
      ret_evt = 1'b1; tick(); ret_evt = 1'b0;
      chk(ctl_rdata == 8'hA0 && irq_take == 1'b0, "R10 clean return", ctl_rdata, 8'hA0);

      // R2 falling edge selected
      pin_rise_sel = 1'b0; pin_async = 1'b0;
      repeat (3) tick();
      chk(ctl_rdata[2] == 1'b1, "R2 falling flag", ctl_rdata[2], 1);
      chk(irq_take == 1'b1, "R3 falling take", irq_take, 1);
      tick();
      write_ctl(8'h20);
      pin_async = 1'b1;
      repeat (5) tick();
      chk(ctl_rdata == 8'h20, "R2 opposite edge ignored", ctl_rdata, 8'h20);

      // R11 software global enable
      write_ctl(8'h80);
      chk(ctl_rdata == 8'h80, "R11 gie write", ctl_rdata, 8'h80);
      write_ctl(8'h00);
      chk(ctl_rdata == 8'h00, "R11 gie clear", ctl_rdata, 0);

      // R4 masked source still flags
      tmr_ovf_evt = 1'b1; tick(); tmr_ovf_evt = 1'b0;
      chk(ctl_rdata == 8'h01, "R4 masked timer flag", ctl_rdata, 1);
      chk(irq_take == 1'b0, "R4 masked no take", irq_take, 0);
      port_chg_evt = 1'b1; tick(); port_chg_evt = 1'b0;
      chk(ctl_rdata == 8'h03, "R4 masked change flag", ctl_rdata, 3);
      write_ctl(8'h89);
      chk(irq_take == 1'b1, "R7 timer enabled take", irq_take, 1);
      tick();
      write_ctl(8'h00);

      // R5 set beats clear
      pflag_wr = 1'b1; pflag_wdata = '0; periph_evt = 5'b00010;
      tick();
      pflag_wr = 1'b0; periph_evt = '0;
      chk(pflag_rdata == 5'b00010, "R5 set wins", pflag_rdata, 2);

      // R8 three-tier gate
      pen_wr = 1'b1; pen_wdata = 5'b00010; tick(); pen_wr = 1'b0;
      write_ctl(8'h80);
      chk(irq_take == 1'b0, "R8 group gate closed", irq_take, 0);
      write_ctl(8'hC0);
      chk(irq_take == 1'b1, "R8 all gates open", irq_take, 1);
      tick();
      write_ctl(8'h00);
      pen_wr = 1'b1; pen_wdata = '0; pflag_wr = 1'b1; pflag_wdata = '0;
      tick();
      pen_wr = 1'b0; pflag_wr = 1'b0;
      chk(pflag_rdata == '0 && pen_rdata == '0, "R6 pflag clear", pflag_rdata, 0);

      // Random phase against bench model (pin held stable)
      m_ctl = 8'h00; m_pf = '0; m_pe = '0; m_take = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         logic chg, tmr, cw, pw, ew, ret;
         logic [7:0] cwd;
         logic [NP-1:0] pev, pwd, ewd;
         logic [2:0] nf;
         logic g;
         chk(ctl_rdata == m_ctl, "R6 random ctl", ctl_rdata, m_ctl);
         chk(pflag_rdata == m_pf, "R5 random pflag", pflag_rdata, m_pf);
         chk(irq_take == m_take, "R7 R8 random take", irq_take, m_take);
         chg = ($urandom % 8) == 0;
         tmr = ($urandom % 8) == 0;
         pev = (($urandom % 4) == 0) ? NP'($urandom) : '0;
         cw  = ($urandom % 6) == 0;  cwd = 8'($urandom);
         pw  = ($urandom % 5) == 0;  pwd = NP'($urandom);
         ew  = ($urandom % 7) == 0;  ewd = NP'($urandom);
         ret = ($urandom % 10) == 0;
         nf  = (cw ? cwd[2:0] : m_ctl[2:0]) | {1'b0, chg, tmr};
         g   = m_take ? 1'b0 : ret ? 1'b1 : cw ? cwd[7] : m_ctl[7];
         m_ctl = {g, (cw ? cwd[6:3] : m_ctl[6:3]), nf};
         m_pf  = (pw ? pwd : m_pf) | pev;
         m_pe  = ew ? ewd : m_pe;
         port_chg_evt = chg; tmr_ovf_evt = tmr; periph_evt = pev;
         ctl_wr = cw; ctl_wdata = cwd; pflag_wr = pw; pflag_wdata = pwd;
         pen_wr = ew; pen_wdata = ewd; ret_evt = ret;
         tick();
         m_take = take_model(m_ctl, m_pf, m_pe);
      end
      port_chg_evt = 1'b0; tmr_ovf_evt = 1'b0; periph_evt = '0;
      ctl_wr = 1'b0; pflag_wr = 1'b0; pen_wr = 1'b0; ret_evt = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule